// File: doc/BRIEF.md
# Frame Sync Flywheel

This block searches a recovered channel-bit stream for the frame sync pattern. A separate enable, produced by the bit-clock recovery loop at an average rate of about 4.32 MHz, qualifies each bit. The block marks the start of each frame so that frame timing stays continuous even when the disc surface hides a sync. A free-running distance counter predicts where the next sync should end. A sync whose last bit falls close enough to that prediction re-anchors the counter. When the prediction window closes with no accepted sync, the counter stands in for the missing sync and the frame strobe still fires.

The frame strobe comes a fixed SLACK bits after the anchor, whether the sync was real or substituted. Because of this fixed delay, the kind of strobe is already settled when the strobe goes out. A kind bit goes with the strobe. A match monitor rises only when a real sync lands exactly on the predicted bit, and it then stays high for one whole frame. A lock flag shows whether the block is following the stream or hunting for it.

Top module: `frame_sync_flywheel`

## Requirements
- R1: A sync is seen on an enabled bit when the latest SYNC_BITS bits, oldest first, equal SYNC_PAT. By default this is eleven zeros, a one, then eleven zeros. Any other run, such as ten zeros, a one and eleven zeros, is not a sync.
- R2: After reset, and until the first sync is seen, frame_stb, stb_true, sync_match and locked all stay low.
- R3: While unlocked, any sync is accepted wherever it falls. It sets locked and becomes the anchor (distance 0; each later enabled bit adds one). frame_stb is then high for the one clock after the enabled bit at distance SLACK (default 2), with stb_true high.
- R4: While locked, a sync whose distance is within FRAME_BITS±SLACK (default 588±2) is accepted and re-anchors the counter. Its strobe follows the timing given in R3.
- R5: While locked, a sync outside that window is ignored. Strobe timing and lock are unchanged.
- R6: If no sync has been accepted by distance FRAME_BITS+SLACK, a substitute strobe fires after that bit with stb_true low. The flywheel then counts on as if a sync had ended at distance FRAME_BITS.
- R7: When locked, MISS_LIMIT (default 8) consecutive substitute strobes clear locked on the last of them. The flywheel keeps running, and the next sync is accepted per R3.
- R8: A sync accepted while locked at exactly distance FRAME_BITS raises sync_match on the next clock. sync_match then stays high through the next FRAME_BITS enabled bits, and each further exact match reloads it.
- R9: A sync accepted off the predicted bit, or while unlocked, does not set sync_match.
- R10: frame_stb is high for one clock only, and only on the clock after an enabled bit.
- R11: A synchronous reset clears lock, the miss count, the anchor, the monitor and the bit history (to all zeros).
- R12: Clocks with bit_en low change no state and raise no strobe, whatever bit_in is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies bit_in for this clock |
| bit_in | input | 1 | Channel bit in transition form |
| frame_stb | output | 1 | Frame start pulse, one clock |
| stb_true | output | 1 | High with frame_stb when a real sync anchored the frame |
| sync_match | output | 1 | Real sync landed on the predicted bit within the last frame |
| locked | output | 1 | Following the stream (low while hunting) |

## Verification
Every cycle, the assertions check the following: strobes follow an enabled bit and never come back to back, a lock loss coincides with a substitute strobe, the monitor rises only while locked, and idle clocks leave lock and monitor unchanged. The scenarios cover the rest. These are the exact strobe positions for early, late and missing syncs, and out-of-window syncs being ignored. They also cover the hunt that follows eight straight misses, and the frame-long hold of the monitor. A bench model checks these bit by bit, on streams with random enable gaps, random phase shifts, dropped syncs and spurious mid-frame syncs.

// File: rtl/frame_sync_flywheel.sv
module frame_sync_flywheel #(
  parameter int FRAME_BITS = 588,
  parameter int SYNC_BITS  = 23,
  parameter logic [SYNC_BITS-1:0] SYNC_PAT = 23'b00000000000_1_00000000000,
  parameter int SLACK      = 2,
  parameter int MISS_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic frame_stb,
  output logic stb_true,
  output logic sync_match,
  output logic locked
);
  localparam int CW   = $clog2(FRAME_BITS + SLACK + 2);
  localparam int MW   = $clog2(MISS_LIMIT + 1);
  localparam int HW   = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] D_LO   = CW'(FRAME_BITS - SLACK);
  localparam logic [CW-1:0] D_HI   = CW'(FRAME_BITS + SLACK);
  localparam logic [CW-1:0] D_MID  = CW'(FRAME_BITS);
  localparam logic [CW-1:0] D_MARK = CW'(SLACK);
  localparam logic [CW-1:0] D_REST = CW'(SLACK + 1);

  logic [SYNC_BITS-2:0] hist_q;
  logic [CW-1:0]        dist_q;
  logic                 have_q;
  logic [MW-1:0]        miss_q;
  logic [HW-1:0]        hold_q;

  wire [SYNC_BITS-1:0] window = {hist_q, bit_in};
  wire seen    = bit_en && (window == SYNC_PAT);
  wire in_gate = (dist_q >= D_LO) && (dist_q <= D_HI);
  wire take    = seen && (!have_q || !locked || in_gate);
  wire fill    = bit_en && have_q && !take && (dist_q == D_HI);
  wire mark    = bit_en && have_q && !take && (dist_q == D_MARK);
  wire hit     = seen && locked && have_q && (dist_q == D_MID);

  assign sync_match = (hold_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q    <= '0;
      dist_q    <= '0;
      have_q    <= 1'b0;
      miss_q    <= '0;
      hold_q    <= '0;
      locked    <= 1'b0;
      frame_stb <= 1'b0;
      stb_true  <= 1'b0;
    end else begin
      frame_stb <= mark || fill;
      stb_true  <= mark;
      if (bit_en) begin
        hist_q <= window[SYNC_BITS-2:0];
        if (take) begin
          dist_q <= CW'(1);
          have_q <= 1'b1;
          locked <= 1'b1;
          miss_q <= '0;
        end else if (fill) begin
          dist_q <= D_REST;
          if (locked) begin
            if (miss_q == MW'(MISS_LIMIT - 1)) begin
              locked <= 1'b0;
              miss_q <= '0;
            end else begin
              miss_q <= miss_q + 1'b1;
            end
          end
        end else if (have_q) begin
          dist_q <= dist_q + 1'b1;
        end
        if (hit)
          hold_q <= HW'(FRAME_BITS);
        else if (hold_q != '0)
          hold_q <= hold_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_sync_flywheel_chk.sv
module frame_sync_flywheel_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic frame_stb,
  input logic stb_true,
  input logic sync_match,
  input logic locked
);
  p_stb_needs_bit_r10: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> $past(bit_en));

  p_stb_isolated_r10: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> !frame_stb);

  p_lock_drop_fills_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> (frame_stb && !stb_true));

  p_match_needs_lock_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_match) |-> $past(locked));

  p_idle_holds_r12: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(locked) && $stable(sync_match) && !frame_stb));
endmodule

bind frame_sync_flywheel frame_sync_flywheel_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .frame_stb(frame_stb),
  .stb_true(stb_true), .sync_match(sync_match), .locked(locked)
);

// File: tb/frame_sync_flywheel_tb.sv
module frame_sync_flywheel_tb;
  localparam int L    = 588;
  localparam int W    = 23;
  localparam int WIN  = 2;
  localparam int MISS = 8;
  localparam logic [W-1:0] PAT = 23'b00000000000_1_00000000000;

  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, bit_in = 1'b0;
  logic frame_stb, stb_true, sync_match, locked;

  frame_sync_flywheel u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .frame_stb(frame_stb), .stb_true(stb_true),
    .sync_match(sync_match), .locked(locked)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, zrun = 0;
  int m_dist, m_miss, m_hold;
  bit m_have, m_track, m_ign, m_offc;
  logic [W-1:0] m_hist;
  string m_stbtag, e_tag;
  bit e_stb, e_kind;
  bit finished = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dist = 0; m_miss = 0; m_hold = 0;
    m_have = 0; m_track = 0; m_ign = 0; m_offc = 0;
    m_hist = '0; m_stbtag = "R3"; zrun = 0;
  endtask

  task automatic model_bit(input bit b);
    logic [W-1:0] win;
    bit det, inw, acc, intp, mark, hit;
    win  = {m_hist[W-2:0], b};
    det  = (win == PAT);
    inw  = (m_dist >= L - WIN) && (m_dist <= L + WIN);
    acc  = det && (!m_have || !m_track || inw);
    intp = m_have && !acc && (m_dist == L + WIN);
    mark = m_have && !acc && (m_dist == WIN);
    hit  = det && m_track && m_have && (m_dist == L);
    if (!m_have) e_tag = "R2";
    else if (intp) e_tag = "R6";
    else if (m_ign) e_tag = "R5";
    else e_tag = m_stbtag;
    e_stb  = mark || intp;
    e_kind = mark;
    if (det && !acc) m_ign = 1;
    m_hist = win;
    if (acc) begin
      m_stbtag = (!m_have || !m_track) ? "R3" : "R4";
      m_ign = 0; m_dist = 1; m_have = 1; m_track = 1; m_miss = 0;
    end else if (intp) begin
      m_dist = WIN + 1;
      if (m_track) begin
        m_miss++;
        if (m_miss == MISS) begin m_track = 0; m_miss = 0; end
      end
    end else if (m_have) begin
      m_dist++;
    end
    if (hit) begin
      m_hold = L; m_offc = 0;
    end else begin
      if (m_hold > 0) m_hold--;
      if (acc) m_offc = 1;
    end
  endtask

  task automatic send_bit(input bit b);
    int gaps;
    bit_en = 1'b1; bit_in = b;
    model_bit(b);
    zrun = b ? 0 : zrun + 1;
    @(negedge clk);
    check(e_tag, frame_stb, e_stb);
    check(e_tag, stb_true, e_kind);
    check(m_offc ? "R9" : "R8", sync_match, m_hold != 0);
    check("R7", locked, m_track);
    gaps = $urandom % 2;
    for (int g = 0; g < gaps; g++) begin
      bit_en = 1'b0; bit_in = 1'($urandom);
      @(negedge clk);
      check("R10", frame_stb, 0);
      check("R12", sync_match, m_hold != 0);
      check("R12", locked, m_track);
    end
    bit_en = 1'b0;
  endtask

  task automatic send_fill(input int n);
    for (int i = 0; i < n; i++) begin
      bit b;
      b = (zrun >= 5) ? 1'b1 : 1'($urandom);
      send_bit(b);
    end
  endtask

  task automatic send_pat();
    for (int i = W - 1; i >= 0; i--) send_bit(PAT[i]);
  endtask

  task automatic send_frame(input int shift, input bit sync_on, input bit extra);
    int body;
    body = L - W + shift;
    if (extra) begin
      send_fill(100); send_pat(); send_fill(body - 100 - W);
    end else begin
      send_fill(body);
    end
    if (sync_on) send_pat(); else send_fill(W);
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    check("R11", frame_stb, 0);
    check("R11", stb_true, 0);
    check("R11", sync_match, 0);
    check("R11", locked, 0);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7321));
    model_reset();
    @(negedge clk);
    do_reset();
    // R2, R1: filler and near-miss runs never lock
    send_fill(700);
    for (int k = 0; k < 3; k++) begin
      send_bit(1'b1);
      for (int i = 0; i < 10; i++) send_bit(1'b0);
      send_bit(1'b1);
      for (int i = 0; i < 11; i++) send_bit(1'b0);
      send_fill(40);
    end
    check("R1", locked, 0);
    // R3, R4, R8: steady frames
    for (int f = 0; f < 6; f++) send_frame(0, 1'b1, 1'b0);
    check("R8", sync_match, 1);
    // R4, R9: in-window early and late
    send_frame(1, 1'b1, 1'b0);
    send_frame(-2, 1'b1, 1'b0);
    send_frame(0, 1'b1, 1'b0);
    // R5, R6, R7: out-of-window phase jump, then loss and re-hunt
    send_frame(3, 1'b1, 1'b0);
    for (int f = 0; f < 10; f++) send_frame(0, 1'b1, 1'b0);
    check("R7", locked, 1);
    // R6: dropped syncs
    send_frame(0, 1'b0, 1'b0);
    send_frame(0, 1'b1, 1'b0);
    send_frame(0, 1'b0, 1'b0);
    send_frame(0, 1'b0, 1'b0);
    send_frame(0, 1'b1, 1'b0);
    // R5: spurious mid-frame sync
    for (int f = 0; f < 3; f++) send_frame(0, 1'b1, 1'b1);
    // R11: reset mid-stream
    send_fill(150);
    do_reset();
    for (int f = 0; f < 2; f++) send_frame(0, 1'b1, 1'b0);
    // mixed random frames
    for (int f = 0; f < 22; f++)
      send_frame(int'($urandom % 7) - 3, ($urandom % 6) != 0, ($urandom % 8) == 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1900000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule